// File: doc/BRIEF.md
# Delayed Power-Good Channel Monitor

This block is one channel of a multi-rail supply supervisor. It takes a digital "rail above threshold" flag from an external comparator, an active-high channel enable and a chip-wide undervoltage-lockout flag. From these it drives a power-good output. The output rises only after a programmable qualification delay. It falls after a short fixed propagation delay when the rail drops. It falls when the enable is withdrawn. It falls at once under lockout. The qualification delay is a cycle counter that takes the place of a capacitor charge timer. A bypass input swaps the programmed delay for a short fixed internal delay.

The enable and rail flags are asynchronous, so each passes through a two-flop synchronizer. The enable then goes through a symmetric glitch filter. The rail flag goes through a filter that only acts on its falling edge, so short dips below threshold are ignored. Channels can be chained to sequence supplies: the power-good output of one channel feeds the enable of the next. The lockout flag is assumed to be synchronous to the clock already.

Top module: `pgood_channel`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the output is low.
- R2: Hold the enable low for at least EN_HOLD clock cycles. The output is then low by the EN_HOLD+3rd clock edge after the first edge that samples the low enable, and it stays low.
- R3: An enable low pulse shorter than EN_HOLD-1 cycles leaves a high output high in every cycle.
- R4: A rail flag low for FALL_CYC cycles or more brings the output low exactly FALL_CYC+2 edges after the first edge that samples it low.
- R5: A rail flag low for fewer than FALL_CYC-1 cycles leaves a high output high.
- R6: With the channel enabled, lockout clear and bypass low, a rising rail flag raises the output max(D,1)+3 edges after the first edge that samples it, where D is the delay input. D = 0 behaves as D = 1.
- R7: With bypass high, the rise delay uses RISE_CYC in place of the delay input.
- R8: The delay input is sampled once, when the timer starts. Changing it during the count does not change that count.
- R9: If the qualifying condition drops during the count, the timer is cleared. The next count starts again from zero.
- R10: If the enable rises while the rail is already good, the full qualification delay still applies: the output rises max(D,1)+EN_HOLD+2 edges after the first edge that samples the enable high.
- R11: Lockout forces the output low in the same cycle and clears the timer. Once lockout is removed, the output rises max(D,1)+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_above | input | 1 | Asynchronous comparator flag, high when the rail is above threshold |
| chan_en | input | 1 | Asynchronous channel enable, active high |
| uvlo | input | 1 | Synchronous lockout flag, high forces the output low |
| dly_bypass | input | 1 | High selects the fixed internal rise delay |
| dly_cycles | input | CNT_W | Programmed rise delay in clock cycles |
| pgood | output | 1 | Power-good output |

## Verification
The output must rise on an exact edge, so any wrong timer state shows up as a rise one or more cycles early or late. A counter that is not cleared on abort makes the retried rise come early, inside the restarted window. A filter counter that does not reset between pulses makes short dips or glitches pull the output low within a few cycles of the pulse. A broken lockout path shows on the output in the very cycle lockout is raised. A bench model that tracks every cycle catches each of these on the first clock where the output differs.

// File: rtl/pgc_pkg.sv
// Shared types for the power-good channel.
package pgc_pkg;
    // Qualification timer state.
    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_GOOD  = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/pgc_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous flags.
// Assumes each bit is a level that needs no coherency with the others.
module pgc_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Two register stages; reset drives both to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pgc_hold_filter.sv
// Pulse filter. The output takes a new input level only after that level
// has been seen on HOLD consecutive cycles. With SYMM = 0 a rising input
// passes at once and only the falling edge is filtered.
// Assumes HOLD >= 1 and an already synchronized input.
module pgc_hold_filter #(
    parameter int HOLD = 4,
    parameter bit SYMM = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] cnt;
    logic          fast_set;

    // Variant choice: symmetric filter, or filter on the falling edge only.
    generate
        if (SYMM) begin : g_sym
            assign fast_set = 1'b0;
        end else begin : g_fall
            assign fast_set = d;
        end
    endgenerate

    // Count consecutive disagreeing samples, then adopt the new level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (d == q) begin
            cnt <= '0;
        end else if (fast_set) begin
            q   <= 1'b1;
            cnt <= '0;
        end else if (cnt == CW'(HOLD - 1)) begin
            q   <= d;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pgc_qual_timer.sv
// Restartable qualification timer. It counts while qual is high and
// declares good once the count reaches a limit latched at the start.
// It is cleared whenever qual drops and held cleared while good.
// Assumes RISE_CYC fits in CNT_W bits.
module pgc_qual_timer
    import pgc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int RISE_CYC = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual,
    input  logic             bypass,
    input  logic [CNT_W-1:0] dly,
    output logic             good
);
    tmr_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Start, count, declare good or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TMR_IDLE;
            cnt   <= '0;
            limit <= '0;
        end else if (!qual) begin
            state <= TMR_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                TMR_IDLE: begin
                    state <= TMR_COUNT;
                    limit <= bypass ? CNT_W'(RISE_CYC) : dly;
                    cnt   <= CNT_W'(1);
                end
                TMR_COUNT: begin
                    if (cnt >= limit) begin
                        state <= TMR_GOOD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // Good flag decoded from state.
    assign good = (state == TMR_GOOD);
endmodule

// File: rtl/pgood_channel.sv
// One supervisor channel: synchronizes the enable and the rail flag, filters
// them, qualifies the rising edge with a timer and gates the result with
// lockout. Assumes uvlo is synchronous to clk.
module pgood_channel #(
    parameter int CNT_W    = 16,
    parameter int RISE_CYC = 35,
    parameter int FALL_CYC = 20,
    parameter int EN_HOLD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rail_above,
    input  logic             chan_en,
    input  logic             uvlo,
    input  logic             dly_bypass,
    input  logic [CNT_W-1:0] dly_cycles,
    output logic             pgood
);
    logic [1:0] sync_q;
    logic       rail_s;
    logic       en_s;
    logic       rail_f;
    logic       en_f;
    logic       qual;
    logic       pg_int;

    pgc_sync #(.WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({chan_en, rail_above}),
        .q    (sync_q)
    );
    assign rail_s = sync_q[0];
    assign en_s   = sync_q[1];

    pgc_hold_filter #(.HOLD(EN_HOLD), .SYMM(1'b1)) u_en_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (en_s),
        .q    (en_f)
    );

    pgc_hold_filter #(.HOLD(FALL_CYC), .SYMM(1'b0)) u_rail_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rail_s),
        .q    (rail_f)
    );

    // Qualifying condition for the timer.
    assign qual = en_f & rail_f & ~uvlo;

    pgc_qual_timer #(.CNT_W(CNT_W), .RISE_CYC(RISE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .qual  (qual),
        .bypass(dly_bypass),
        .dly   (dly_cycles),
        .good  (pg_int)
    );

    // Lockout gates the output without waiting for a clock edge.
    assign pgood = pg_int & ~uvlo;
endmodule

// File: rtl/pgood_channel_chk.sv
// Checker for pgood_channel, attached with bind. It watches filter, timer
// and output relations over time.
module pgood_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic uvlo,
    input logic rail_s,
    input logic en_s,
    input logic rail_f,
    input logic en_f,
    input logic qual,
    input logic pg_int
);
    assert_lockout_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> !pg_int);

    assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_f |=> !pg_int);

    assert_rail_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_f |=> !pg_int);

    assert_rise_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_int) |-> $past(qual));

    assert_rail_fall_filtered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_f) |-> !$past(rail_s));

    assert_en_fall_filtered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_f) |-> !$past(en_s));

    assert_en_rise_filtered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_f) |-> $past(en_s));
endmodule

bind pgood_channel pgood_channel_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .uvlo  (uvlo),
    .rail_s(rail_s),
    .en_s  (en_s),
    .rail_f(rail_f),
    .en_f  (en_f),
    .qual  (qual),
    .pg_int(pg_int)
);

// File: tb/pgood_channel_tb.sv
module pgood_channel_tb;
    localparam int TCLK  = 10;
    localparam int CW    = 16;
    localparam int RISE  = 35;
    localparam int FALL  = 20;
    localparam int ENH   = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rail_above;
    logic          chan_en;
    logic          uvlo;
    logic          dly_bypass;
    logic [CW-1:0] dly_cycles;
    logic          pgood;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state
    bit m_r1, m_r2, m_e1, m_e2, m_enf, m_railf, m_pg;
    int m_encnt, m_fcnt, m_run, m_lim;

    always #(TCLK/2) clk = ~clk;

    pgood_channel #(.CNT_W(CW), .RISE_CYC(RISE), .FALL_CYC(FALL), .EN_HOLD(ENH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_above(rail_above),
        .chan_en   (chan_en),
        .uvlo      (uvlo),
        .dly_bypass(dly_bypass),
        .dly_cycles(dly_cycles),
        .pgood     (pgood)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pgood=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model, advanced once per rising edge from the driven inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_r1 = 0; m_r2 = 0; m_e1 = 0; m_e2 = 0;
            m_enf = 0; m_railf = 0; m_pg = 0;
            m_encnt = 0; m_fcnt = 0; m_run = 0; m_lim = 0;
        end else begin
            if (!(m_enf && m_railf && !uvlo)) begin
                m_run = 0;
                m_pg  = 0;
            end else if (!m_pg) begin
                m_run++;
                if (m_run == 1) m_lim = dly_bypass ? RISE : int'(dly_cycles);
                if (m_run == ((m_lim < 1) ? 1 : m_lim) + 1) m_pg = 1;
            end
            if (m_e2 == m_enf) m_encnt = 0;
            else if (m_encnt == ENH - 1) begin m_enf = m_e2; m_encnt = 0; end
            else m_encnt++;
            if (m_r2) begin m_railf = 1; m_fcnt = 0; end
            else if (m_railf) begin
                if (m_fcnt == FALL - 1) begin m_railf = 0; m_fcnt = 0; end
                else m_fcnt++;
            end
            m_r2 = m_r1; m_r1 = rail_above;
            m_e2 = m_e1; m_e1 = chan_en;
        end
    end

    // Compare against the model a quarter period after every edge
    always @(posedge clk) begin
        #(TCLK/4);
        if (cmp_on) chk(pgood, m_pg && !uvlo, cur_req);
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: finished=0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; rail_above = 0; chan_en = 0; uvlo = 0;
        dly_bypass = 0; dly_cycles = CW'(10);
        cyc(5);
        rst_n = 1; cmp_on = 1;
        #1 chk(pgood, 1'b0, "R1");

        // R6: enable and rail together, D = 10
        cur_req = "R6";
        chan_en = 1; rail_above = 1;
        cyc(16); #1 chk(pgood, 1'b0, "R6");
        cyc(1);  #1 chk(pgood, 1'b1, "R6");

        // R5: short rail dip ignored
        cur_req = "R5";
        rail_above = 0; cyc(FALL - 5); rail_above = 1;
        for (int i = 0; i < 30; i++) begin cyc(1); #1 chk(pgood, 1'b1, "R5"); end

        // R4: long rail drop, exact fall edge
        cur_req = "R4";
        rail_above = 0;
        cyc(FALL + 2); #1 chk(pgood, 1'b1, "R4");
        cyc(1);        #1 chk(pgood, 1'b0, "R4");

        // R8: delay input changed after the timer has started
        cur_req = "R8";
        rail_above = 1; cyc(6); dly_cycles = CW'(200);
        cyc(30); #1 chk(pgood, 1'b1, "R8");
        dly_cycles = CW'(10);

        // R3: short enable glitch ignored
        cur_req = "R3";
        chan_en = 0; cyc(ENH - 2); chan_en = 1;
        for (int i = 0; i < 20; i++) begin cyc(1); #1 chk(pgood, 1'b1, "R3"); end

        // R2: enable held low
        cur_req = "R2";
        chan_en = 0;
        cyc(ENH + 2); #1 chk(pgood, 1'b1, "R2");
        cyc(1);       #1 chk(pgood, 1'b0, "R2");
        cyc(10);      #1 chk(pgood, 1'b0, "R2");

        // R10: enable rises with rail already good
        cur_req = "R10";
        chan_en = 1;
        cyc(ENH + 12); #1 chk(pgood, 1'b0, "R10");
        cyc(1);        #1 chk(pgood, 1'b1, "R10");

        // R7: bypass uses the fixed internal delay
        cur_req = "R7";
        rail_above = 0; cyc(FALL + 5);
        dly_bypass = 1; dly_cycles = CW'(500);
        rail_above = 1;
        cyc(RISE + 3); #1 chk(pgood, 1'b0, "R7");
        cyc(1);        #1 chk(pgood, 1'b1, "R7");

        // R9: abort during count, restart from zero
        cur_req = "R9";
        dly_bypass = 0; dly_cycles = CW'(40);
        rail_above = 0; cyc(FALL + 5);
        rail_above = 1; cyc(10);
        rail_above = 0; cyc(FALL + 5);
        rail_above = 1;
        cyc(43); #1 chk(pgood, 1'b0, "R9");
        cyc(1);  #1 chk(pgood, 1'b1, "R9");

        // R11: lockout forces low at once, full delay after release
        cur_req = "R11";
        uvlo = 1; #1 chk(pgood, 1'b0, "R11");
        cyc(5); #1 chk(pgood, 1'b0, "R11");
        uvlo = 0;
        cyc(40); #1 chk(pgood, 1'b0, "R11");
        cyc(1);  #1 chk(pgood, 1'b1, "R11");

        // R6: zero delay behaves as one
        cur_req = "R6";
        dly_cycles = CW'(0);
        rail_above = 0; cyc(FALL + 5);
        rail_above = 1;
        cyc(4); #1 chk(pgood, 1'b0, "R6");
        cyc(1); #1 chk(pgood, 1'b1, "R6");

        cyc(5);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule